// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter that software reaches through two byte-wide registers: an 8-bit up-counter and a control/status byte. The counter is clocked from a prescaler. A 3-bit select code in the control byte picks one of eight power-of-two divide ratios, from 32 to 4096. Each step of the code doubles the time to overflow. When the count rolls over from its largest value to zero, the block latches a flag in the control byte and drives a one-cycle pulse on its overflow output.

Software cannot change either register by accident. Each write is a 16-bit word, and its upper byte must hold the key that belongs to the target register. The key is 0x5A for the counter and 0xA5 for the control byte. A word with any other upper byte is dropped silently. Reads return the 8-bit value of the selected register and change nothing. Reloading the counter also restarts the prescaler, so after a reload the next count step is a full prescale period away.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the counter reads 0x00, the control byte reads 0x00 (select code 0, timer stopped, flag clear), and the overflow output is low.
- R2: A write to the counter (wrAddr=0) whose bits [15:8] equal 0x5A loads bits [7:0] into the counter at the next clock edge and clears the prescaler.
- R3: A write to the control byte (wrAddr=1) whose bits [15:8] equal 0xA5 loads the run-enable bit 5 and the select field bits [2:0] from bits [7:0]. Bits 6, 4 and 3 always read as 0.
- R4: A write whose upper byte is not the key of the addressed register changes neither register. This includes the other register's key.
- R5: While the run-enable bit is 1, the counter advances by one every 2^(5+sel) clocks, counted from the last counter write (sel 0..7 gives ratios 32..4096). While the bit is 0, the counter holds.
- R6: When the counter wraps from 0xFF to 0x00, the flag in bit 7 of the control byte sets, and the overflow output is high for exactly the one cycle after the wrapping edge.
- R7: A keyed control-byte write with bit 7 = 0 clears the flag. Writing bit 7 = 1 never sets the flag. If a wrap lands on the same edge as a clearing write, the flag stays set.
- R8: If a keyed counter write lands on the same edge as a count step, the written value is loaded and no increment is added.
- R9: The read data is combinational from rdAddr: 0 returns the counter and 1 returns the control byte. Reading has no side effects.
- R10: At select code 0, starting from a count of 0, the overflow pulse appears exactly 8192 clocks after the counter write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe, one word per cycle |
| wrAddr | input | 1 | Write target: 0 counter, 1 control byte |
| wrData | input | 16 | Key in [15:8], value in [7:0] |
| rdAddr | input | 1 | Read select: 0 counter, 1 control byte |
| rdData | output | 8 | Selected register value |
| ovfPulse | output | 1 | One-cycle pulse on counter wrap |

## Verification
Two kinds of event can fall on the same clock edge, and the bench sets up both of them. The first is a counter wrap that coincides with a keyed write clearing the flag. The second is a prescaler step that coincides with a keyed counter reload. To set these up, the bench reloads the counter, which restarts the prescaler, and then counts clocks so that the write strobe is active on exactly the edge where the prescaler completes. In the wrap case, the pass condition is a flag that remains set together with the pulse. In the reload case, the pass condition is the written value with no increment added, followed by a full prescale period before the next step.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from the control section to the datapath, valid for one cycle.
  typedef struct packed {
    logic loadCnt;  // keyed counter write accepted
    logic loadCsr;  // keyed control-byte write accepted
    logic tick;     // prescaler period complete
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SEL_W      = 3,
  parameter int BASE_SHIFT = 5,
  parameter logic [DATA_W-1:0] KEY_CNT = 8'h5A,
  parameter logic [DATA_W-1:0] KEY_CSR = 8'hA5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  wrAddr,
  input  logic [2*DATA_W-1:0]   wrData,
  input  logic                  timerEn,
  input  logic [SEL_W-1:0]      clkSel,
  output wdtStrobe_t            strobe
);
  localparam int PRE_W = BASE_SHIFT + (1 << SEL_W) - 1;
  localparam int SH_W  = $clog2(PRE_W + 1);

  logic [DATA_W-1:0] keyByte;
  logic [PRE_W-1:0]  preQ;
  logic [SH_W-1:0]   shiftAmt;
  logic [PRE_W:0]    maskWide;
  logic [PRE_W-1:0]  mask;

  assign keyByte  = wrData[2*DATA_W-1:DATA_W];
  assign shiftAmt = SH_W'(BASE_SHIFT) + SH_W'(clkSel);
  assign maskWide = ({{PRE_W{1'b0}}, 1'b1} << shiftAmt) - 1'b1;
  assign mask     = maskWide[PRE_W-1:0];

  always_comb begin
    strobe.loadCnt = wrEn && !wrAddr && (keyByte == KEY_CNT);
    strobe.loadCsr = wrEn &&  wrAddr && (keyByte == KEY_CSR);
    strobe.tick    = timerEn && (&(preQ | ~mask));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 preQ <= '0;
    else if (strobe.loadCnt)   preQ <= '0;
    else if (timerEn)          preQ <= preQ + 1'b1;
  end

  // Counter reload restarts the prescaler (R2).
  assert_pre_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCnt |=> (preQ == '0));
  // Prescale periods are at least 32 clocks, so steps never come back to back (R5).
  assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |=> !strobe.tick);
endmodule

// File: rtl/wdt_dp.sv
module wdt_dp
  import wdt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int EN_BIT = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  wdtStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrByte,
  input  logic               rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               timerEn,
  output logic [SEL_W-1:0]   clkSel,
  output logic               ovfPulse
);
  localparam int FLAG_BIT = DATA_W - 1;

  logic [DATA_W-1:0] cntQ;
  logic              flagQ;
  logic              wrap;
  logic [DATA_W-1:0] csrView;

  assign wrap = strobe.tick && !strobe.loadCnt && (&cntQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntQ <= '0;
    else if (strobe.loadCnt) cntQ <= wrByte;
    else if (strobe.tick)    cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ    <= 1'b0;
      timerEn  <= 1'b0;
      clkSel   <= '0;
      ovfPulse <= 1'b0;
    end else begin
      ovfPulse <= wrap;
      if (wrap)                flagQ <= 1'b1;
      else if (strobe.loadCsr) flagQ <= flagQ & wrByte[FLAG_BIT];
      if (strobe.loadCsr) begin
        timerEn <= wrByte[EN_BIT];
        clkSel  <= wrByte[SEL_W-1:0];
      end
    end
  end

  always_comb begin
    csrView              = '0;
    csrView[FLAG_BIT]    = flagQ;
    csrView[EN_BIT]      = timerEn;
    csrView[SEL_W-1:0]   = clkSel;
    rdData               = rdAddr ? csrView : cntQ;
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCnt |=> (cntQ == $past(wrByte)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadCnt && !strobe.tick) |=> $stable(cntQ));
  assert_pulse_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> flagQ);
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> !ovfPulse);
  assert_flag_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !strobe.loadCsr) |=> flagQ);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SEL_W      = 3,
  parameter int BASE_SHIFT = 5,
  parameter int EN_BIT     = 5,
  parameter logic [DATA_W-1:0] KEY_CNT = 8'h5A,
  parameter logic [DATA_W-1:0] KEY_CSR = 8'hA5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                wrAddr,
  input  logic [2*DATA_W-1:0] wrData,
  input  logic                rdAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic                ovfPulse
);
  wdtStrobe_t       strobe;
  logic             timerEn;
  logic [SEL_W-1:0] clkSel;

  wdt_ctrl #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT),
    .KEY_CNT(KEY_CNT), .KEY_CSR(KEY_CSR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timerEn(timerEn), .clkSel(clkSel), .strobe(strobe)
  );

  wdt_dp #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .EN_BIT(EN_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrByte(wrData[DATA_W-1:0]),
    .rdAddr(rdAddr), .rdData(rdData), .timerEn(timerEn), .clkSel(clkSel),
    .ovfPulse(ovfPulse)
  );
endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrAddr = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdAddr = 1'b0;
  logic [7:0]  rdData;
  logic        ovfPulse;

  int checks = 0;
  int fails = 0;

  keyed_watchdog u_keyed_watchdog (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .ovfPulse(ovfPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Drive one write at a negedge; it lands on the following posedge.
  task automatic wr(input logic addr, input logic [15:0] data);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic addr, output int value);
    rdAddr = addr;
    #1;
    value = int'(rdData);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int v, period, done;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk("R1 counter", v, 0);
    rd(1'b1, v); chk("R1 control", v, 0);
    chk("R1 pulse", int'(ovfPulse), 0);

    // R2 counter load, R3 control load with unused bits masked
    wr(1'b0, 16'h5A37); rd(1'b0, v); chk("R2 load", v, 8'h37);
    wr(1'b1, 16'hA55B); rd(1'b1, v); chk("R3 control fields", v, 8'h03);

    // R9 reads have no side effects
    for (int i = 0; i < 4; i++) begin
      rd(1'b1, v); chk("R9 control reread", v, 8'h03);
      rd(1'b0, v); chk("R9 counter reread", v, 8'h37);
    end

    // R4 wrong keys, including the swapped key
    wr(1'b0, 16'hA599); wr(1'b0, 16'h0011); wr(1'b0, 16'h5B22); wr(1'b0, 16'hFF33);
    wr(1'b1, 16'h5A27); wr(1'b1, 16'h0027); wr(1'b1, 16'hA427); wr(1'b1, 16'hFFA7);
    rd(1'b0, v); chk("R4 counter untouched", v, 8'h37);
    rd(1'b1, v); chk("R4 control untouched", v, 8'h03);

    // R5 hold while disabled
    idle(300);
    rd(1'b0, v); chk("R5 hold when disabled", v, 8'h37);

    // R5 sweep of all select codes
    for (int s = 0; s < 8; s++) begin
      period = 1 << (5 + s);
      wr(1'b1, 16'hA520 | 16'(s));
      wr(1'b0, 16'h5A00);
      done = 0;
      for (int k = 1; k <= 3; k++) begin
        idle(k * period - 1 - done); done = k * period - 1;
        rd(1'b0, v); chk($sformatf("R5 sel%0d before step%0d", s, k), v, k - 1);
        idle(1); done++;
        rd(1'b0, v); chk($sformatf("R5 sel%0d step%0d", s, k), v, k);
      end
    end

    // R6 wrap at 0xFF
    wr(1'b1, 16'hA520);
    wr(1'b0, 16'h5AFF);
    idle(31);
    rd(1'b0, v); chk("R6 before wrap", v, 8'hFF);
    chk("R6 pulse low before wrap", int'(ovfPulse), 0);
    idle(1);
    rd(1'b0, v); chk("R6 wrapped count", v, 0);
    rd(1'b1, v); chk("R6 flag set", v, 8'hA0);
    chk("R6 pulse high", int'(ovfPulse), 1);
    idle(1);
    chk("R6 pulse one cycle", int'(ovfPulse), 0);

    // R7 writing 1 keeps the flag, writing 0 clears, 1 never sets
    wr(1'b1, 16'hA5A0); rd(1'b1, v); chk("R7 write one keeps flag", v, 8'hA0);
    wr(1'b1, 16'hA520); rd(1'b1, v); chk("R7 clear flag", v, 8'h20);
    wr(1'b1, 16'hA5A0); rd(1'b1, v); chk("R7 one does not set", v, 8'h20);

    // R7 wrap on the same edge as a clearing write
    wr(1'b0, 16'h5AFF);
    idle(31);
    wr(1'b1, 16'hA521);
    rd(1'b1, v); chk("R7 set beats clear", v, 8'hA1);
    chk("R7 pulse on collision", int'(ovfPulse), 1);
    rd(1'b0, v); chk("R7 count wrapped", v, 0);
    wr(1'b1, 16'hA520); rd(1'b1, v); chk("R7 clear after collision", v, 8'h20);

    // R8 counter write on the same edge as a step
    wr(1'b0, 16'h5A10);
    idle(31);
    wr(1'b0, 16'h5A40);
    rd(1'b0, v); chk("R8 write wins over step", v, 8'h40);
    idle(31);
    rd(1'b0, v); chk("R8 prescaler restarted", v, 8'h40);
    idle(1);
    rd(1'b0, v); chk("R8 next step", v, 8'h41);

    // R10 full period at divide by 32
    wr(1'b0, 16'h5A00);
    idle(8191);
    rd(1'b0, v); chk("R10 count before overflow", v, 8'hFF);
    chk("R10 no pulse at 8191", int'(ovfPulse), 0);
    idle(1);
    chk("R10 pulse at 8192", int'(ovfPulse), 1);
    rd(1'b1, v); chk("R10 flag at 8192", v, 8'hA0);

    summary();
  end
endmodule